// File: doc/BRIEF.md
# Four-Bit ECC Correction Sequencer

This block drives the controller-side sequence that repairs one 512-byte NAND sector protected by a four-error-correcting parity code. A single `start` pulse hands it the ten parity bytes read from the spare area. If every parity byte is 0xFF, the sector counts as erased and the block ends at once. Otherwise it splits the 80 parity bits into eight 10-bit values. It pushes these into the load port of an external syndrome engine, highest slice first. It then spends one cycle on a dummy status read and samples the four syndrome words.

If the masked syndrome is zero, the sector is clean. If it is not, the block issues a clear read of the first error-address register and then a location-start pulse. It then polls the engine's 4-bit correction state in two phases. In the first phase it waits for the state to leave the range 0..3. In the second it waits for the state to come back into that range. For a correctable result it reads up to four address/value pairs. For each one it emits an XOR update for the sector buffer, which sits outside the block. The syndrome and locator arithmetic belong to the engine.

Top module: `ecc4_fix_seq`

## Requirements
- R1: When all ten parity bytes (par_in[79:0]) equal 0xFF, the run ends with result 3 (erased). No load, status read, clear read, start or fix pulse is issued.
- R2: Otherwise, exactly eight load pulses are issued on consecutive cycles. Load k (k = 0..7) carries par_in bits [10*(7-k)+9 : 10*(7-k)], with byte n of the parity at bits [8n+7:8n].
- R3: Exactly one status-read pulse follows, in the cycle right after the last load. The syndrome is sampled in the cycle after that pulse.
- R4: The syndrome is the four 32-bit words of eng_syn, each ANDed with 0x03FF03FF. If the result is zero, the run ends with result 0 (clean) and no clear read or start pulse.
- R5: A non-zero masked syndrome gives one clear-read pulse, followed in the next cycle by one start pulse.
- R6: After start, the block polls eng_state until it exceeds 3, then until it is 3 or less. A final state of 0 gives result 0, state 1 gives result 2 (uncorrectable), and state 2 or 3 goes on to correction and gives result 1 (fixed).
- R7: If either polling phase sees TMO polls in a row without its exit condition, the run ends with result 2.
- R8: The number of errors is eng_cnt + 1. Error 0 is taken from bits [9:0]/[7:0] of eng_addr_a/eng_val_a, and error 1 from bits [25:16]/[23:16] of the same words. Errors 2 and 3 are taken the same way from eng_addr_b/eng_val_b. Updates are issued in that order.
- R9: For each error with 10-bit address A, the byte index is 519 - A. A fix pulse with that index and the 8-bit value as XOR mask is issued only when the index is below 512 (8 <= A <= 519).
- R10: done is high for exactly one cycle, with res valid in that cycle. After reset the block is idle and every output pulse is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (accepted when idle) |
| par_in | input | 80 | Ten stored parity bytes, byte n at [8n+7:8n] |
| eng_load | output | 1 | Load-port write strobe |
| eng_load_val | output | 10 | 10-bit parity value for the load port |
| eng_stat_rd | output | 1 | Dummy status read before syndrome sampling |
| eng_syn | input | 128 | Four syndrome words, word w at [32w+31:32w] |
| eng_clr_rd | output | 1 | Dummy read clearing the previous address result |
| eng_go | output | 1 | Start of error-location calculation |
| eng_state | input | 4 | Correction state from the engine |
| eng_cnt | input | 2 | Number of errors minus one |
| eng_addr_a | input | 32 | Error addresses 0 (low half) and 1 (high half) |
| eng_addr_b | input | 32 | Error addresses 2 (low half) and 3 (high half) |
| eng_val_a | input | 32 | Error values 0 (low half) and 1 (high half) |
| eng_val_b | input | 32 | Error values 2 (low half) and 3 (high half) |
| fix_we | output | 1 | Sector-buffer XOR update strobe |
| fix_idx | output | 9 | Byte index to update |
| fix_mask | output | 8 | XOR mask for that byte |
| done | output | 1 | One-cycle end-of-run pulse |
| res | output | 2 | 0 clean, 1 fixed, 2 uncorrectable, 3 erased |

## Verification
All outputs are Moore outputs of the state register, so each one is due in the cycle after the edge that enters its state. Counting from the edge that captures `start`, the first load appears one cycle later, and the status read appears nine cycles later. The clear read and the start pulse follow the syndrome cycle at offsets of eleven and twelve.

The bench drives its inputs on falling edges and samples every output on each falling edge. It records pulses and their order rather than fixed offsets. This lets it check the back-to-back relations (the loads, then the status read, then clear, then start) against the exact cycle in which each is due. The polling phases run through a small engine model with a fixed busy time, and the two timeout cases drive a state that never changes.

// File: rtl/ecc4_fix_seq.sv
module ecc4_fix_seq #(
  parameter int TMO = 10240
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [79:0]  par_in,
  output logic         eng_load,
  output logic [9:0]   eng_load_val,
  output logic         eng_stat_rd,
  input  logic [127:0] eng_syn,
  output logic         eng_clr_rd,
  output logic         eng_go,
  input  logic [3:0]   eng_state,
  input  logic [1:0]   eng_cnt,
  input  logic [31:0]  eng_addr_a,
  input  logic [31:0]  eng_addr_b,
  input  logic [31:0]  eng_val_a,
  input  logic [31:0]  eng_val_b,
  output logic         fix_we,
  output logic [8:0]   fix_idx,
  output logic [7:0]   fix_mask,
  output logic         done,
  output logic [1:0]   res
);
  localparam int PW = $clog2(TMO + 1);
  localparam logic [1:0] R_CLEAN = 2'd0, R_FIXED = 2'd1, R_FAIL = 2'd2, R_ERASED = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_LOAD, S_SRD, S_SYN, S_CLR, S_GO, S_W1, S_W2, S_FIX, S_DONE
  } st_t;

  st_t         st;
  logic [79:0] par_q;
  logic [2:0]  k;
  logic [1:0]  fi, n_q;
  logic [PW-1:0] poll;
  logic [1:0]  res_q;

  logic        syn_nz, in_rng;
  logic [31:0] aw, vw;
  logic [9:0]  addr;
  logic [10:0] diff;

  assign syn_nz = |(eng_syn & {4{32'h03FF03FF}});
  assign aw     = fi[1] ? eng_addr_b : eng_addr_a;
  assign vw     = fi[1] ? eng_val_b  : eng_val_a;
  assign addr   = fi[0] ? aw[25:16] : aw[9:0];
  assign diff   = 11'd519 - {1'b0, addr};
  assign in_rng = (addr >= 10'd8) && (addr <= 10'd519);

  assign eng_load     = (st == S_LOAD);
  assign eng_load_val = par_q[79 - 10*k -: 10];
  assign eng_stat_rd  = (st == S_SRD);
  assign eng_clr_rd   = (st == S_CLR);
  assign eng_go       = (st == S_GO);
  assign fix_we       = (st == S_FIX) && in_rng;
  assign fix_idx      = diff[8:0];
  assign fix_mask     = fi[0] ? vw[23:16] : vw[7:0];
  assign done         = (st == S_DONE);
  assign res          = res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      par_q <= '0;
      k     <= '0;
      fi    <= '0;
      n_q   <= '0;
      poll  <= '0;
      res_q <= R_CLEAN;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          par_q <= par_in;
          k     <= '0;
          if (&par_in) begin
            res_q <= R_ERASED;
            st    <= S_DONE;
          end else st <= S_LOAD;
        end
        S_LOAD: begin
          k <= k + 3'd1;
          if (k == 3'd7) st <= S_SRD;
        end
        S_SRD: st <= S_SYN;
        S_SYN: if (syn_nz) st <= S_CLR;
               else begin res_q <= R_CLEAN; st <= S_DONE; end
        S_CLR: st <= S_GO;
        S_GO: begin poll <= '0; st <= S_W1; end
        S_W1: begin
          if (eng_state > 4'd3) begin poll <= '0; st <= S_W2; end
          else if (poll == PW'(TMO - 1)) begin res_q <= R_FAIL; st <= S_DONE; end
          else poll <= poll + 1'b1;
        end
        S_W2: begin
          if (eng_state <= 4'd3) begin
            if (eng_state == 4'd0)      begin res_q <= R_CLEAN; st <= S_DONE; end
            else if (eng_state == 4'd1) begin res_q <= R_FAIL;  st <= S_DONE; end
            else begin n_q <= eng_cnt; fi <= '0; st <= S_FIX; end
          end else if (poll == PW'(TMO - 1)) begin res_q <= R_FAIL; st <= S_DONE; end
          else poll <= poll + 1'b1;
        end
        S_FIX: begin
          fi <= fi + 2'd1;
          if (fi == n_q) begin res_q <= R_FIXED; st <= S_DONE; end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  erased_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_load |-> !(&par_q));
  // R3
  srd_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eng_load) |-> eng_stat_rd);
  // R5
  go_after_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_clr_rd |=> eng_go);
  // R7
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll < PW'(TMO));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  fix_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fix_we |-> !done && !eng_load);
endmodule

// File: tb/tb_ecc4_fix_seq.sv
module tb_ecc4_fix_seq;
  logic clk = 0, rst_n = 0, start = 0;
  logic [79:0] par_in = '0;
  logic [127:0] eng_syn = '0;
  logic [3:0] eng_state;
  logic [1:0] eng_cnt = 0;
  logic [31:0] eng_addr_a = 0, eng_addr_b = 0, eng_val_a = 0, eng_val_b = 0;
  logic eng_load, eng_stat_rd, eng_clr_rd, eng_go, fix_we, done;
  logic [9:0] eng_load_val;
  logic [8:0] fix_idx;
  logic [7:0] fix_mask;
  logic [1:0] res;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  ecc4_fix_seq dut (.*);

  logic [1:0] mode = 0;
  logic [3:0] fin = 0;
  logic act = 0;
  logic [3:0] t = 0;
  always @(posedge clk) begin
    if (start) act <= 1'b0;
    else if (eng_go) begin act <= 1'b1; t <= 0; end
    else if (act && t != 4'hF) t <= t + 1;
  end
  assign eng_state = !act ? 4'd0 : (mode == 1) ? 4'd0 :
                     (mode == 2) ? ((t < 3) ? 4'd0 : 4'd9) :
                     ((t < 3) ? 4'd0 : (t < 8) ? 4'hA : fin);

  typedef struct packed {
    logic [79:0] par;
    logic [31:0] syn;
    logic [3:0]  fin;
    logic [1:0]  cnt;
    logic [31:0] a0, a1, v0, v1;
    logic [1:0]  mode;
    logic [1:0]  eres;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{ {10{8'hFF}}, 32'h1, 4'd2, 2'd0, 32'h0, 32'h0, 32'h0, 32'h0, 2'd0, 2'd3 },
    '{ {8'hFE, {9{8'hFF}}}, 32'h0, 4'd0, 2'd0, 32'h0, 32'h0, 32'h0, 32'h0, 2'd0, 2'd0 },
    '{ 80'h0123_4567_89AB_CDEF_1357, 32'hFC00FC00, 4'd2, 2'd0, 32'h0, 32'h0, 32'h0, 32'h0, 2'd0, 2'd0 },
    '{ 80'hA5A5_5A5A_0F0F_F0F0_3C3C, 32'h00000001, 4'd0, 2'd0, 32'h0, 32'h0, 32'h0, 32'h0, 2'd0, 2'd0 },
    '{ 80'h1111_2222_3333_4444_5555, 32'h00200000, 4'd1, 2'd0, 32'h0, 32'h0, 32'h0, 32'h0, 2'd0, 2'd2 },
    '{ 80'hDEAD_BEEF_CAFE_F00D_0042, 32'h00000100, 4'd2, 2'd3,
       {16'd8, 16'd519}, {16'd300, 16'd7}, {16'h0040, 16'h00A5}, {16'h0011, 16'h0022}, 2'd0, 2'd1 },
    '{ 80'h0000_0000_0000_0000_0001, 32'h00000200, 4'd3, 2'd0,
       {16'd0, 16'hFC64}, 32'h0, {16'h0, 16'hFF3C}, 32'h0, 2'd0, 2'd1 },
    '{ 80'h8000_0000_0000_0000_0000, 32'h00000004, 4'd2, 2'd0, 32'h0, 32'h0, 32'h0, 32'h0, 2'd1, 2'd2 },
    '{ 80'h7FFF_FFFF_FFFF_FFFF_FFFF, 32'h00000008, 4'd2, 2'd0, 32'h0, 32'h0, 32'h0, 32'h0, 2'd2, 2'd2 }
  };

  task automatic chk(input bit ok, input string tag, input longint act_v, input longint exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
    end
  endtask

  task automatic run(input vec_t v, input int id);
    logic [9:0] ld [8];
    logic [8:0] fx_i [4];
    logic [7:0] fx_m [4];
    logic [8:0] ex_i [4];
    logic [7:0] ex_m [4];
    int nld = 0, nfx = 0, nex = 0, nsrd = 0, nclr = 0, ngo = 0, cyc = 0;
    int srd_at = -1, last_ld = -1, clr_at = -1, go_at = -1;
    bit erased, synz, got = 0;
    logic [1:0] r = 0;
    erased = &v.par;
    synz = ((v.syn & 32'h03FF03FF) == 0);
    par_in = v.par; eng_syn = {32'h0, v.syn, 64'h0}; fin = v.fin; eng_cnt = v.cnt;
    eng_addr_a = v.a0; eng_addr_b = v.a1; eng_val_a = v.v0; eng_val_b = v.v1; mode = v.mode;
    start = 1;
    @(negedge clk); start = 0;
    while (cyc < 25000) begin
      if (eng_load) begin if (nld < 8) ld[nld] = eng_load_val; nld++; last_ld = cyc; end
      if (eng_stat_rd) begin nsrd++; srd_at = cyc; end
      if (eng_clr_rd) begin nclr++; clr_at = cyc; end
      if (eng_go) begin ngo++; go_at = cyc; end
      if (fix_we) begin if (nfx < 4) begin fx_i[nfx] = fix_idx; fx_m[nfx] = fix_mask; end nfx++; end
      if (done) begin got = 1; r = res; break; end
      @(negedge clk); cyc++;
    end
    chk(got, $sformatf("R10 vec%0d done seen", id), got, 1);
    chk(r == v.eres, $sformatf("R6 R7 vec%0d result", id), r, v.eres);
    @(negedge clk);
    chk(!done, $sformatf("R10 vec%0d done one cycle", id), done, 0);
    if (erased) begin
      chk(nld + nsrd + nclr + ngo + nfx == 0, $sformatf("R1 vec%0d no activity", id), nld + nsrd + nclr + ngo + nfx, 0);
      return;
    end
    chk(nld == 8, $sformatf("R2 vec%0d load count", id), nld, 8);
    for (int k = 0; k < 8 && k < nld; k++)
      chk(ld[k] == v.par[10*(7-k) +: 10], $sformatf("R2 vec%0d load %0d", id, k), ld[k], v.par[10*(7-k) +: 10]);
    chk(nsrd == 1 && srd_at == last_ld + 1, $sformatf("R3 vec%0d status read", id), srd_at, last_ld + 1);
    if (synz) begin
      chk(nclr + ngo == 0, $sformatf("R4 vec%0d no start", id), nclr + ngo, 0);
      return;
    end
    chk(nclr == 1 && ngo == 1 && go_at == clr_at + 1 && clr_at == srd_at + 2,
        $sformatf("R5 vec%0d clear then start", id), go_at, clr_at + 1);
    if (v.mode == 0 && v.fin >= 2) begin
      for (int i = 0; i <= v.cnt; i++) begin
        logic [31:0] aw, vw;
        logic [9:0] a;
        aw = (i < 2) ? v.a0 : v.a1;
        vw = (i < 2) ? v.v0 : v.v1;
        a = i[0] ? aw[25:16] : aw[9:0];
        if (a >= 8 && a <= 519) begin
          ex_i[nex] = 9'(519 - a);
          ex_m[nex] = i[0] ? vw[23:16] : vw[7:0];
          nex++;
        end
      end
    end
    chk(nfx == nex, $sformatf("R8 vec%0d fix count", id), nfx, nex);
    for (int i = 0; i < nex && i < nfx; i++)
      chk(fx_i[i] == ex_i[i] && fx_m[i] == ex_m[i], $sformatf("R9 vec%0d fix %0d", id, i),
          {fx_i[i], fx_m[i]}, {ex_i[i], ex_m[i]});
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !eng_load && !fix_we && !eng_go, "R10 reset idle", {done, eng_load, fix_we, eng_go}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!done && !eng_load && !eng_stat_rd, "R10 idle after reset", {done, eng_load, eng_stat_rd}, 0);
    for (int i = 0; i < 9; i++) begin
      run(VEC[i], i);
      @(negedge clk);
    end
    par_in = 80'h1;
    @(negedge clk);
    chk(!eng_load && !done, "R10 no run without start", {eng_load, done}, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule